// File: doc/BRIEF.md
# Inrush-Limited Channel Activation Sequencer

This block sits between the host-side activation bits of four line-driver channels and the drivers themselves. Switching a channel on charges its load capacitance at the programmed current limit. To keep the die from heating, only one channel may be in that limited phase at a time. Activation requests are level bits. The drivers report back, one bit per channel, whether they are still current limiting. The sequencer grants one channel, waits until its current-limit status has cleared, and then grants the next one.

Requests that arrive while a channel is charging are held in a pending set. The pending set is served from the lowest channel index upward, so arrival order does not matter. Switching a channel off is never queued. When the request bit drops, the driver enable drops in the same cycle. A bypass input turns the sequencing off, and each enable then follows its request directly. An active-low asynchronous reset turns every driver off and empties the pending set. The block runs from its own slow clock, nominally a few kHz.

Top module: `inrush_sequencer`

## Requirements
- R1: At most one bit of `pon_flag_o` is high at any time. A channel's flag goes high in the same cycle that its enable is granted.
- R2: Pending channels are granted in ascending index order (bit 0 first), whatever order their requests arrived in.
- R3: When the sequencer is idle, a request that rises on a disabled channel before clock edge E is enabled at the next edge after E.
- R4: After a grant, the synchronized current-limit bit of the active channel is ignored for `HOLD_CYC` edges. The flag then clears at the first edge that sees that bit low, and the next pending channel is granted at the edge after that. The current-limit input passes through a `SYNC_STAGES` flop synchronizer.
- R5: While the active channel stays in current limiting, no other channel is granted, however long that lasts.
- R6: Clearing a request bit drops that channel's enable and flag at once, with no clock edge needed. A pending request that is withdrawn is never granted.
- R7: When the active channel's request is withdrawn, the sequencer goes idle at the next edge and grants the lowest pending channel at the edge after that.
- R8: A channel that is enabled and stays requested is not sequenced again, and no flag rises for it.
- R9: With `bypass_i` high, `drv_en_o` equals `act_req_i` combinationally, all flags are low and nothing is held pending. Channels that are enabled when bypass is released stay enabled and are not sequenced again.
- R10: Taking `rst_ni` low clears every enable and flag at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Slow sequencer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bypass_i | input | 1 | 1 = sequencing disabled, enables follow requests |
| act_req_i | input | N_CH | Per-channel activation request level, bit i = channel i |
| cur_lim_i | input | N_CH | Per-channel current-limit status from the drivers, asynchronous |
| drv_en_o | output | N_CH | Per-channel driver enable |
| pon_flag_o | output | N_CH | Per-channel power-on flag, high while that channel is in its charging phase |

## Verification
The testbench models each driver: current limiting lasts a fixed number of edges after its enable rises, or forever when a fault is injected. This makes every result due at a computable edge. A grant from idle comes two edges after the request is driven. Successive grants are spaced by the charge time plus the synchronizer depth plus two edges. After the active channel is withdrawn, the next grant comes two edges later. Deactivation, bypass and reset results must appear within the same cycle. Inputs change on the falling edge. Results that depend on an edge are sampled 3 ns after the rising edge, and combinational results are sampled 1 ns after the input change. A sweep over all fifteen non-empty request masks checks the order and the exact grant cycles against these counts.

// File: rtl/inrush_pkg.sv
package inrush_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } seq_state_t;
endpackage

// File: rtl/cl_sync.sv
module cl_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/lowest_pick.sv
module lowest_pick #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [N-1:0]     oh_o
);
  always_comb begin
    idx_o = '0;
    oh_o  = '0;
    for (int i = N-1; i >= 0; i--) begin
      if (req_i[i]) begin
        idx_o = IDX_W'(i);
        oh_o  = N'(1) << i;
      end
    end
  end

  assign any_o = |req_i;
endmodule

// File: rtl/inrush_sequencer.sv
module inrush_sequencer
  import inrush_pkg::*;
#(
  parameter int unsigned N_CH        = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned HOLD_CYC    = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            bypass_i,
  input  logic [N_CH-1:0] act_req_i,
  input  logic [N_CH-1:0] cur_lim_i,
  output logic [N_CH-1:0] drv_en_o,
  output logic [N_CH-1:0] pon_flag_o
);
  localparam int unsigned IDX_W = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int unsigned CNT_W = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;

  seq_state_t       st_q, st_d;
  logic [IDX_W-1:0] act_q, act_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [N_CH-1:0]  req_q, en_q, en_d, pend_q, pend_d;
  logic [N_CH-1:0]  cl_s, rise, pend_live, pick_oh, act_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;

  cl_sync #(.WIDTH(N_CH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cur_lim_i),
    .q_o   (cl_s)
  );

  // only a fresh request on a disabled channel joins the queue
  assign rise      = act_req_i & ~req_q & ~en_q;
  assign pend_live = pend_q & act_req_i;

  lowest_pick #(.N(N_CH), .IDX_W(IDX_W)) u_pick (
    .req_i(pend_live),
    .any_o(pick_any),
    .idx_o(pick_idx),
    .oh_o (pick_oh)
  );

  assign act_oh = N_CH'(1) << act_q;

  always_comb begin
    st_d   = st_q;
    act_d  = act_q;
    cnt_d  = cnt_q;
    en_d   = en_q & act_req_i;
    pend_d = (pend_q | rise) & act_req_i;
    if (bypass_i) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      en_d   = act_req_i;
      pend_d = '0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (pick_any) begin
            st_d   = ST_BUSY;
            act_d  = pick_idx;
            cnt_d  = CNT_W'(HOLD_CYC);
            en_d   = en_d | pick_oh;
            pend_d = pend_d & ~pick_oh;
          end
        end
        ST_BUSY: begin
          if (!act_req_i[act_q])   st_d  = ST_IDLE;
          else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
          else if (!cl_s[act_q])   st_d  = ST_IDLE;
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      act_q  <= '0;
      cnt_q  <= '0;
      req_q  <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      st_q   <= st_d;
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      req_q  <= act_req_i;
      en_q   <= en_d;
      pend_q <= pend_d;
    end
  end

  // switch-off path is combinational: no edge needed
  assign drv_en_o   = bypass_i ? act_req_i : (en_q & act_req_i);
  assign pon_flag_o = (!bypass_i && st_q == ST_BUSY) ? (act_oh & act_req_i) : '0;
endmodule

// File: rtl/inrush_sequencer_chk.sv
module inrush_sequencer_chk #(
  parameter int unsigned N_CH = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            bypass_i,
  input logic [N_CH-1:0] act_req_i,
  input logic [N_CH-1:0] drv_en_o,
  input logic [N_CH-1:0] pon_flag_o
);
  p_one_flag_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(pon_flag_o));

  p_flag_with_en_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pon_flag_o & ~drv_en_o) == '0);

  p_no_grant_in_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !$past(bypass_i) && (|$past(pon_flag_o)))
      |-> ((drv_en_o & ~$past(drv_en_o)) == '0));

  p_off_follows_req_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o & ~act_req_i) == '0);

  p_bypass_pass_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |-> (drv_en_o == act_req_i && pon_flag_o == '0));
endmodule

bind inrush_sequencer inrush_sequencer_chk #(.N_CH(N_CH)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .bypass_i  (bypass_i),
  .act_req_i (act_req_i),
  .drv_en_o  (drv_en_o),
  .pon_flag_o(pon_flag_o)
);

// File: tb/sim_inrush_sequencer.sv
`timescale 1ns/1ps
module sim_inrush_sequencer;
  localparam int N   = 4;
  localparam int CHG = 5;
  localparam int GAP = CHG + 2 + 2;  // charge + sync depth + decide/grant

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         bypass_i = 1'b0;
  logic [N-1:0] act_req_i = '0;
  logic [N-1:0] cur_lim_i;
  logic [N-1:0] drv_en_o, pon_flag_o;

  int checks = 0, failures = 0;
  int cyc = 0;
  int n_ev = 0;
  int ev_ch [64];
  int ev_cyc[64];
  int chg [N];
  logic [N-1:0] stuck = '0;
  logic [N-1:0] prev_en = '0;
  int mon_bad = 0;

  always #10 clk_i = ~clk_i;

  inrush_sequencer #(.N_CH(N), .SYNC_STAGES(2), .HOLD_CYC(3)) u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .bypass_i(bypass_i),
    .act_req_i(act_req_i), .cur_lim_i(cur_lim_i),
    .drv_en_o(drv_en_o), .pon_flag_o(pon_flag_o));

  // driver model: limiting lasts CHG edges after enable, or forever if stuck
  always_ff @(posedge clk_i) begin
    for (int k = 0; k < N; k++) begin
      if (!drv_en_o[k]) chg[k] <= CHG;
      else if (chg[k] != 0) chg[k] <= chg[k] - 1;
    end
  end
  always_comb
    for (int k = 0; k < N; k++)
      cur_lim_i[k] = drv_en_o[k] & ((chg[k] != 0) | stuck[k]);

  always @(posedge clk_i) begin
    cyc++;
    #3;
    for (int k = 0; k < N; k++) begin
      if (drv_en_o[k] && !prev_en[k] && !bypass_i) begin
        if (n_ev < 64) begin ev_ch[n_ev] = k; ev_cyc[n_ev] = cyc; n_ev++; end
        if (!pon_flag_o[k]) mon_bad++;
      end
    end
    if ($countones(pon_flag_o) > 1) mon_bad++;
    prev_en = drv_en_o;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    summary();
  end

  initial begin
    int c0, exp_i;
    cycles(3);
    #1;
    chk(drv_en_o == 0 && pon_flag_o == 0, "R10 reset state", drv_en_o, 0);
    rst_ni = 1'b1;
    cycles(3);

    // R2 R3 R4: every non-empty mask raised at once
    for (int m = 1; m < 16; m++) begin
      @(negedge clk_i);
      n_ev = 0; c0 = cyc;
      act_req_i = 4'(m);
      cycles(GAP * 4 + 10);
      chk(n_ev == $countones(m), "R2 grant count", n_ev, $countones(m));
      exp_i = 0;
      for (int b = 0; b < N; b++) begin
        if (m[b]) begin
          if (exp_i < n_ev) begin
            chk(ev_ch[exp_i] == b, "R2 ascending order", ev_ch[exp_i], b);
            chk(ev_cyc[exp_i] == c0 + 2 + GAP * exp_i, "R3 R4 grant cycle",
                ev_cyc[exp_i], c0 + 2 + GAP * exp_i);
          end
          exp_i++;
        end
      end
      chk(pon_flag_o == 0, "R4 flag cleared after charge", pon_flag_o, 0);
      if (m == 15) begin
        n_ev = 0;
        cycles(20);
        chk(n_ev == 0 && pon_flag_o == 0 && drv_en_o == 15, "R8 held channels not resequenced",
            n_ev, 0);
      end
      act_req_i = '0;
      #1;
      chk(drv_en_o == 0, "R6 immediate off", drv_en_o, 0);
      cycles(3);
    end

    // R2: arrivals 1,3,0 during channel 2 phase -> 2,0,1,3
    @(negedge clk_i);
    n_ev = 0; c0 = cyc;
    act_req_i = 4'b0100;
    cycles(3); act_req_i[1] = 1'b1;
    cycles(1); act_req_i[3] = 1'b1;
    cycles(1); act_req_i[0] = 1'b1;
    cycles(GAP * 4 + 6);
    chk(n_ev == 4, "R2 arrival count", n_ev, 4);
    chk(ev_ch[0] == 2 && ev_ch[1] == 0 && ev_ch[2] == 1 && ev_ch[3] == 3,
        "R2 arrival order ignored", ev_ch[1], 0);
    chk(ev_cyc[3] == c0 + 2 + GAP * 3, "R4 last grant cycle", ev_cyc[3], c0 + 2 + GAP * 3);
    act_req_i = '0; cycles(3);

    // R5 R6 R7: channel 1 stuck blocks channel 2
    stuck = 4'b0010;
    @(negedge clk_i);
    n_ev = 0;
    act_req_i = 4'b0110;
    cycles(60);
    chk(n_ev == 1 && ev_ch[0] == 1, "R5 blocked on stuck channel", n_ev, 1);
    chk(pon_flag_o == 4'b0010, "R5 flag held", pon_flag_o, 2);
    c0 = cyc;
    act_req_i = 4'b0100;
    #1;
    chk(drv_en_o == 0 && pon_flag_o == 0, "R6 withdrawn active off at once", drv_en_o, 0);
    cycles(4);
    chk(n_ev == 2 && ev_ch[1] == 2, "R7 next channel granted", n_ev, 2);
    chk(ev_cyc[1] == c0 + 2, "R7 grant two edges after withdrawal", ev_cyc[1], c0 + 2);
    stuck = '0;
    cycles(GAP + 2);
    act_req_i = '0; cycles(3);

    // R6: pending channel withdrawn is skipped
    @(negedge clk_i);
    n_ev = 0; c0 = cyc;
    act_req_i = 4'b0111;
    cycles(4);
    act_req_i[1] = 1'b0;
    cycles(GAP * 3);
    chk(n_ev == 2 && ev_ch[0] == 0 && ev_ch[1] == 2, "R6 withdrawn pending skipped",
        n_ev, 2);
    chk(ev_cyc[1] == c0 + 2 + GAP, "R6 next grant cycle", ev_cyc[1], c0 + 2 + GAP);
    act_req_i = '0; cycles(3);

    // R9: bypass
    @(negedge clk_i);
    bypass_i = 1'b1;
    act_req_i = 4'b1010;
    #1;
    chk(drv_en_o == 4'b1010 && pon_flag_o == 0, "R9 bypass passthrough", drv_en_o, 10);
    cycles(5);
    act_req_i[3] = 1'b0;
    #1;
    chk(drv_en_o == 4'b0010, "R9 bypass off passthrough", drv_en_o, 2);
    act_req_i[3] = 1'b1;
    cycles(2);
    n_ev = 0;
    bypass_i = 1'b0;
    cycles(GAP * 2);
    chk(n_ev == 0 && drv_en_o == 4'b1010 && pon_flag_o == 0, "R9 no resequence after bypass",
        n_ev, 0);
    act_req_i = '0; cycles(3);

    // R10: async reset mid phase
    @(negedge clk_i);
    act_req_i = 4'b0001;
    cycles(3);
    chk(drv_en_o == 4'b0001 && pon_flag_o == 4'b0001, "R1 flag with enable", pon_flag_o, 1);
    #5;
    rst_ni = 1'b0;
    #1;
    chk(drv_en_o == 0 && pon_flag_o == 0, "R10 async clear", drv_en_o, 0);
    act_req_i = '0;
    cycles(2);
    rst_ni = 1'b1;
    cycles(2);

    chk(mon_bad == 0, "R1 single flag rising with enable", mon_bad, 0);
    summary();
  end
endmodule